// File: doc/BRIEF.md
# Packed Horizontal Pair Add/Subtract Unit

This datapath takes two packed operands and, inside each one, combines every adjacent pair of signed elements into a single value. Even element `2k` and odd element `2k+1` are added, or the odd element is subtracted from the even one. The pair values from the first operand are packed into the lower part of the result, and the pair values from the second operand are packed directly above them. Elements are 16 or 32 bits wide. Sums and differences either wrap or, for 16-bit elements only, clamp to the signed 16-bit range.

A mode input picks between a 64-bit register view and a 128-bit register view. In the 64-bit view only the low 64 bits of each operand take part, and the result occupies only the low 64 bits. The unit sits after decode and operand fetch. Each accepted request produces one registered result one cycle later, marked by an output strobe. Two select codes are not supported; they raise an illegal flag and return zero.

Top module: `hz_pair_unit`

## Requirements
- R1: Select code 1 adds each 16-bit pair (element 2k plus element 2k+1) and keeps the low 16 bits of the signed sum, so 0x7FFF+0x0001 gives 0x8000.
- R2: Select codes 2 and 6 operate on 32-bit pairs and keep the low 32 bits of the sum (code 2) or of the difference (code 6).
- R3: Select code 3 adds 16-bit pairs and clamps the sum to the range -32768..32767, so 0x7FFF+0x0001 gives 0x7FFF and 0x8000+0x8000 gives 0x8000.
- R4: Select codes 5 (wrap) and 7 (clamp) compute element 2k minus element 2k+1 on 16-bit pairs, so 0x8000-0x0001 gives 0x7FFF under code 5 and 0x8000 under code 7. The select is read as bit 2 = subtract and bits 1:0 = element kind.
- R5: With the mode input at 1 (128-bit view), result words 0..3 hold the four pair values of the first operand in order and words 4..7 hold those of the second operand. For 32-bit elements, doublewords 0..1 come from the first operand and doublewords 2..3 from the second.
- R6: With the mode input at 0 (64-bit view), result words 0..1 come from the first operand and words 2..3 from the second (doubleword 0 from the first operand and doubleword 1 from the second). Result bits 127:64 are zero, and operand bits 127:64 have no effect.
- R7: Select codes 0 and 4 set the illegal output together with the output strobe and give a zero result.
- R8: The result, the illegal flag and the output strobe appear exactly one cycle after the input strobe. Reset, which is synchronous and active high, clears all three.
- R9: While the input strobe is low, the output strobe and the illegal flag are 0 on the next cycle and the result holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Bit 2 = subtract, bits 1:0 = kind (1 word wrap, 2 dword wrap, 3 word clamp, 0 illegal) |
| wide_mode | input | 1 | 1 = 128-bit view, 0 = 64-bit view |
| src_a | input | 128 | First operand; its pairs fill the lower part of the result |
| src_b | input | 128 | Second operand; its pairs fill the upper part of the result |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 128 | Packed pair results |
| out_illegal | output | 1 | Unsupported select seen on the accepted request |

## Verification
Each element slot gets a distinct operand value, so a misplaced lane or an operand swap shows up as a wrong word. The boundary pairs 0x7FFF+1, 0x8000-1 and 0x8000+0x8000 each run under both the wrapping and the clamping codes, which separates the two arithmetic paths and shows the order of the subtraction operands. The 64-bit view runs with random junk in the upper operand halves, to show those bits have no effect and the upper result stays zero. Random selects, including the two illegal codes, mixed with idle cycles then exercise the latency and hold behaviour against a behavioural model.

// File: rtl/hz_pair_pkg.sv
package hz_pair_pkg;

    typedef enum logic [1:0] {
        KIND_NONE     = 2'd0,
        KIND_WORD     = 2'd1,
        KIND_DWORD    = 2'd2,
        KIND_WORD_SAT = 2'd3
    } pair_kind_e;

    typedef struct packed {
        logic       sub;
        pair_kind_e kind;
    } pair_op_t;

    localparam int WORD_W  = 16;
    localparam int DWORD_W = 32;

endpackage

// File: rtl/hz_pair_lane.sv
module hz_pair_lane #(
    parameter int EW = 16
) (
    input  logic [EW-1:0] even_el,
    input  logic [EW-1:0] odd_el,
    input  logic          sub_en,
    input  logic          sat_en,
    output logic [EW-1:0] pair_res
);
    localparam logic [EW-1:0] POS_MAX = {1'b0, {(EW-1){1'b1}}};
    localparam logic [EW-1:0] NEG_MIN = {1'b1, {(EW-1){1'b0}}};

    logic signed [EW:0] ext_even, ext_odd, ext_val;
    logic               overflow;

    always_comb begin
        ext_even = {even_el[EW-1], even_el};
        ext_odd  = {odd_el[EW-1], odd_el};
        ext_val  = sub_en ? (ext_even - ext_odd) : (ext_even + ext_odd);
        overflow = ext_val[EW] ^ ext_val[EW-1];
        if (sat_en && overflow)
            pair_res = ext_val[EW] ? NEG_MIN : POS_MAX;
        else
            pair_res = ext_val[EW-1:0];
    end
endmodule

// File: rtl/hz_operand_pairs.sv
module hz_operand_pairs #(
    parameter int VEC_W = 128,
    parameter int EW    = 16
) (
    input  logic [VEC_W-1:0]   src,
    input  logic               sub_en,
    input  logic               sat_en,
    output logic [VEC_W/2-1:0] pairs
);
    localparam int NPAIR = VEC_W / (2 * EW);

    for (genvar k = 0; k < NPAIR; k++) begin : g_lane
        hz_pair_lane #(.EW(EW)) u_lane (
            .even_el (src[EW*(2*k)   +: EW]),
            .odd_el  (src[EW*(2*k+1) +: EW]),
            .sub_en  (sub_en),
            .sat_en  (sat_en),
            .pair_res(pairs[EW*k +: EW])
        );
    end
endmodule

// File: rtl/hz_pair_unit.sv
module hz_pair_unit
    import hz_pair_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       op_sel,
    input  logic             wide_mode,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_result,
    output logic             out_illegal
);
    localparam int NW   = VEC_W / WORD_W;
    localparam int NPW  = NW / 2;
    localparam int ND   = VEC_W / DWORD_W;
    localparam int NPD  = ND / 2;
    localparam int HALF = VEC_W / 2;

    pair_op_t op;
    assign op = pair_op_t'(op_sel);

    logic sat_w;
    assign sat_w = (op.kind == KIND_WORD_SAT);

    logic [HALF-1:0] pa_w, pb_w, pa_d, pb_d;

    hz_operand_pairs #(.VEC_W(VEC_W), .EW(WORD_W)) u_word_a (
        .src(src_a), .sub_en(op.sub), .sat_en(sat_w), .pairs(pa_w));
    hz_operand_pairs #(.VEC_W(VEC_W), .EW(WORD_W)) u_word_b (
        .src(src_b), .sub_en(op.sub), .sat_en(sat_w), .pairs(pb_w));
    hz_operand_pairs #(.VEC_W(VEC_W), .EW(DWORD_W)) u_dword_a (
        .src(src_a), .sub_en(op.sub), .sat_en(1'b0), .pairs(pa_d));
    hz_operand_pairs #(.VEC_W(VEC_W), .EW(DWORD_W)) u_dword_b (
        .src(src_b), .sub_en(op.sub), .sat_en(1'b0), .pairs(pb_d));

    logic [VEC_W-1:0] wide_w, narrow_w, wide_d, narrow_d;

    for (genvar j = 0; j < NW; j++) begin : g_wpack
        if (j < NPW) begin : g_lo
            assign wide_w[WORD_W*j +: WORD_W] = pa_w[WORD_W*j +: WORD_W];
        end else begin : g_hi
            assign wide_w[WORD_W*j +: WORD_W] = pb_w[WORD_W*(j-NPW) +: WORD_W];
        end
        if (j < NPW/2) begin : g_nlo
            assign narrow_w[WORD_W*j +: WORD_W] = pa_w[WORD_W*j +: WORD_W];
        end else if (j < NPW) begin : g_nhi
            assign narrow_w[WORD_W*j +: WORD_W] = pb_w[WORD_W*(j-NPW/2) +: WORD_W];
        end else begin : g_nz
            assign narrow_w[WORD_W*j +: WORD_W] = '0;
        end
    end

    for (genvar j = 0; j < ND; j++) begin : g_dpack
        if (j < NPD) begin : g_lo
            assign wide_d[DWORD_W*j +: DWORD_W] = pa_d[DWORD_W*j +: DWORD_W];
        end else begin : g_hi
            assign wide_d[DWORD_W*j +: DWORD_W] = pb_d[DWORD_W*(j-NPD) +: DWORD_W];
        end
        if (j < NPD/2) begin : g_nlo
            assign narrow_d[DWORD_W*j +: DWORD_W] = pa_d[DWORD_W*j +: DWORD_W];
        end else if (j < NPD) begin : g_nhi
            assign narrow_d[DWORD_W*j +: DWORD_W] = pb_d[DWORD_W*(j-NPD/2) +: DWORD_W];
        end else begin : g_nz
            assign narrow_d[DWORD_W*j +: DWORD_W] = '0;
        end
    end

    logic             bad_op;
    logic [VEC_W-1:0] next_res;

    always_comb begin
        bad_op = (op.kind == KIND_NONE);
        if (bad_op)
            next_res = '0;
        else if (op.kind == KIND_DWORD)
            next_res = wide_mode ? wide_d : narrow_d;
        else
            next_res = wide_mode ? wide_w : narrow_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= next_res;
                out_illegal <= bad_op;
            end else begin
                out_illegal <= 1'b0;
            end
        end
    end

    // R8: one-cycle latency of the strobe
    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R9: idle input gives idle output and held result
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && $stable(out_result)));
    // R7: unsupported select flags and zeroes
    p_illegal_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel[1:0] == 2'd0) |=> (out_illegal && out_result == '0));
    // R7: the flag only comes with a strobe
    p_illegal_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_valid);
    // R6: narrow view leaves the upper result zero
    p_narrow_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_mode) |=> (out_result[VEC_W-1:HALF] == '0));
endmodule

// File: tb/hz_pair_unit_test.sv
module hz_pair_unit_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   op_sel;
    logic         wide_mode;
    logic [127:0] src_a, src_b;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_illegal;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic         exp_valid = 1'b0;
    logic [127:0] exp_res   = '0;
    logic         exp_ill   = 1'b0;

    always #2 clk = ~clk;

    hz_pair_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .wide_mode(wide_mode), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal));

    function automatic logic [127:0] model(input logic [2:0] op, input logic wide,
                                           input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r = '0;
        bit sub = op[2];
        int kind = int'(op[1:0]);
        if (kind == 0) return '0;
        if (kind == 2) begin
            int np = wide ? 2 : 1;
            for (int j = 0; j < np; j++) begin
                longint x0 = $signed(a[64*j +: 32]);
                longint x1 = $signed(a[64*j+32 +: 32]);
                longint y0 = $signed(b[64*j +: 32]);
                longint y1 = $signed(b[64*j+32 +: 32]);
                longint ra = sub ? x0 - x1 : x0 + x1;
                longint rb = sub ? y0 - y1 : y0 + y1;
                r[32*j +: 32]      = ra[31:0];
                r[32*(j+np) +: 32] = rb[31:0];
            end
        end else begin
            int np = wide ? 4 : 2;
            for (int j = 0; j < np; j++) begin
                int x0 = $signed(a[32*j +: 16]);
                int x1 = $signed(a[32*j+16 +: 16]);
                int y0 = $signed(b[32*j +: 16]);
                int y1 = $signed(b[32*j+16 +: 16]);
                int ra = sub ? x0 - x1 : x0 + x1;
                int rb = sub ? y0 - y1 : y0 + y1;
                if (kind == 3) begin
                    if (ra > 32767) ra = 32767;
                    if (ra < -32768) ra = -32768;
                    if (rb > 32767) rb = 32767;
                    if (rb < -32768) rb = -32768;
                end
                r[16*j +: 16]      = ra[15:0];
                r[16*(j+np) +: 16] = rb[15:0];
            end
        end
        return r;
    endfunction

    task automatic check(input string tag);
        n_tests++;
        if (out_valid !== exp_valid || out_result !== exp_res || out_illegal !== exp_ill) begin
            n_fail++;
            $display("FAIL %s: got v=%0b ill=%0b res=%h exp v=%0b ill=%0b res=%h",
                     tag, out_valid, out_illegal, out_result, exp_valid, exp_ill, exp_res);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic wide,
                        input logic [127:0] a, input logic [127:0] b, input string tag);
        @(negedge clk);
        in_valid = v; op_sel = op; wide_mode = wide; src_a = a; src_b = b;
        if (v) begin
            exp_valid = 1'b1;
            exp_res   = model(op, wide, a, b);
            exp_ill   = (op[1:0] == 2'd0);
        end else begin
            exp_valid = 1'b0;
            exp_ill   = 1'b0;
        end
        @(posedge clk);
        #1;
        check(tag);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [127:0] seq_a, seq_b, junk_hi;
        rst = 1'b1; in_valid = 1'b0; op_sel = '0; wide_mode = 1'b0;
        src_a = '0; src_b = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset");
        @(negedge clk);
        rst = 1'b0;

        seq_a = 128'h0008_0007_0006_0005_0004_0003_0002_0001;
        seq_b = 128'h0080_0070_0060_0050_0040_0030_0020_0010;
        step(1, 3'd1, 1, seq_a, seq_b, "R5 word placement");
        step(1, 3'd1, 1, {96'h0, 16'h0001, 16'h7FFF}, '0, "R1 wrap 7FFF+1");
        step(1, 3'd3, 1, {96'h0, 16'h0001, 16'h7FFF}, {96'h0, 16'h8000, 16'h8000},
             "R3 clamp 7FFF+1 and 8000+8000");
        step(1, 3'd5, 1, {96'h0, 16'h0001, 16'h8000}, seq_b, "R4 wrap 8000-1");
        step(1, 3'd7, 1, {96'h0, 16'h0001, 16'h8000}, {96'h0, 16'h8000, 16'h7FFF},
             "R4 clamp 8000-1 and 7FFF-8000");
        step(1, 3'd2, 1, {32'h4, 32'h3, 32'h0000_0001, 32'h7FFF_FFFF},
             {32'h40, 32'h30, 32'h20, 32'h10}, "R2 dword add wrap");
        step(1, 3'd6, 1, {32'h1, 32'h9, 32'h0000_0001, 32'h8000_0000},
             {32'h5, 32'h50, 32'h20, 32'h10}, "R2 dword sub wrap");
        junk_hi = {64'hDEAD_BEEF_CAFE_F00D, 64'h0};
        step(1, 3'd1, 0, junk_hi | seq_a, junk_hi | seq_b, "R6 narrow word");
        step(1, 3'd7, 0, junk_hi | 128'h8000_7FFF_0001_8000, ~junk_hi & seq_b | junk_hi,
             "R6 narrow clamp sub");
        step(1, 3'd2, 0, junk_hi | 128'h5_0000_0003, junk_hi | 128'h7_0000_0009,
             "R6 narrow dword");
        step(1, 3'd0, 1, seq_a, seq_b, "R7 illegal code 0");
        step(1, 3'd4, 0, seq_a, seq_b, "R7 illegal code 4");
        step(1, 3'd3, 1, seq_a, seq_b, "R3 clamp no overflow");
        step(0, 3'd1, 1, rnd128(), rnd128(), "R9 hold idle");
        step(0, 3'd0, 0, rnd128(), rnd128(), "R9 hold idle illegal code");

        for (int i = 0; i < 60; i++) begin
            logic v = ($urandom % 4) != 0;
            logic [2:0] op = 3'($urandom);
            logic w = 1'($urandom);
            step(v, op, w, rnd128(), rnd128(), "R1 R2 R3 R4 R7 R9 random");
        end

        @(negedge clk);
        rst = 1'b1;
        exp_valid = 1'b0; exp_res = '0; exp_ill = 1'b0;
        @(posedge clk);
        #1;
        check("R8 reset clears");

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule